// File: doc/BRIEF.md
# Programmable CRC Engine with Register Access

This block computes a running cyclic redundancy check over data written to it through a small register port. Software picks a generator polynomial and a start value, then chooses the CRC width (32, 16, 8 or 7 bits). It can mirror the bit order of the incoming data and of the returned result. After that it streams payload into the data register and reads the data register to get the checksum. The bus access width of each data write sets how many bytes are folded in, so one write can absorb one, two or four bytes.

Out of reset the engine computes the MSB-first CRC-32 (polynomial 0x04C11DB7, start value all ones), and it never applies a final inversion. The reflected zip-style CRC-32 is reached by turning on input and output mirroring and complementing the read value in software. A control bit reloads the running value from the start-value register. That bit reads back as set for one cycle only.

Top module: `crc_periph`

## Requirements
- R1: After reset the data register (offset 0x00) reads 0xFFFFFFFF, control (0x04) reads 0, start value (0x10) reads 0xFFFFFFFF and polynomial (0x14) reads 0x04C11DB7.
- R2: With reset settings, the bytes of "123456789" written one by one give 0x0376E6E7 with no final XOR.
- R3: A data write folds bytes by its strobe pattern: 0001, 0010, 0100 or 1000 take the one enabled byte; 0011 or 1100 take that halfword; 1111 takes all four bytes. Bytes go most significant first, and bits within them MSB first. A full-width write of 0x00000031 therefore folds four bytes, not one.
- R4: A data write with any other strobe pattern (0000, 0101, 0110, ...) leaves the CRC unchanged.
- R5: A control write with bit 0 set loads the CRC from the start-value register, masked to the CRC width, at that edge. Control bit 0 reads 1 in the following cycle and 0 after that.
- R6: Control bits 6:5 mirror input data: 00 none, 01 within each byte, 10 within each halfword, 11 across the word. The span never exceeds the access width.
- R7: Control bit 7 mirrors the read-back result across the selected CRC width.
- R8: Control bits 4:3 set the width: 00 32-bit, 01 16-bit, 10 8-bit, 11 7-bit. Polynomial and start value use their low bits, and data-register bits above the width read 0. Check values are 0x29B1 (poly 0x1021, start 0xFFFF), 0xF4 (poly 0x07, start 0) and 0x75 (poly 0x09, start 0).
- R9: Writes to control, start value and polynomial honour byte strobes. Control keeps only bits 7:3 plus the one-cycle bit 0. Reads return the register at `addr` combinationally, unmapped offsets read 0, and a data write is visible on the next cycle.
- R10: With input mirroring per byte, output mirroring and start 0xFFFFFFFF, "123456789" reads 0x340BC6D9, the complement of the zip CRC-32 check value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Byte offset for both write and read |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte enables; for the data register they also set the access width |
| rdata | output | 32 | Read data of the register at `addr` |

## Verification
The checks that run every cycle are these. The CRC holds steady when no data or control write lands, and a malformed strobe on the data register changes nothing. A reload takes the masked start value, and the reload flag drops after one cycle. Data reads never show bits above the chosen width. The arithmetic itself can only be shown by scenarios with known check values. Those cover each width, each mirroring mode under byte, halfword and word writes, the lane placement of narrow writes, and a full-width write standing in for a byte write.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    IREV_NONE = 2'b00,
    IREV_BYTE = 2'b01,
    IREV_HALF = 2'b10,
    IREV_WORD = 2'b11
  } irev_e;

  typedef enum logic [1:0] {
    PSZ_32 = 2'b00,
    PSZ_16 = 2'b01,
    PSZ_8  = 2'b10,
    PSZ_7  = 2'b11
  } psize_e;

  function automatic logic [BUS_W-1:0] width_mask(psize_e s);
    case (s)
      PSZ_32:  return 32'hFFFF_FFFF;
      PSZ_16:  return 32'h0000_FFFF;
      PSZ_8:   return 32'h0000_00FF;
      default: return 32'h0000_007F;
    endcase
  endfunction

  function automatic logic [4:0] top_index(psize_e s);
    case (s)
      PSZ_32:  return 5'd31;
      PSZ_16:  return 5'd15;
      PSZ_8:   return 5'd7;
      default: return 5'd6;
    endcase
  endfunction

  function automatic logic [5:0] refl_shift(psize_e s);
    case (s)
      PSZ_32:  return 6'd0;
      PSZ_16:  return 6'd16;
      PSZ_8:   return 6'd24;
      default: return 6'd25;
    endcase
  endfunction

  // mirror bit order inside consecutive units of ub bits
  function automatic logic [BUS_W-1:0] rev_units(logic [BUS_W-1:0] v, int unsigned ub);
    logic [BUS_W-1:0] r;
    for (int unsigned i = 0; i < BUS_W; i++)
      r[i] = v[(i / ub) * ub + (ub - 1) - (i % ub)];
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] byte_merge(logic [BUS_W-1:0] old_v,
                                                  logic [BUS_W-1:0] new_v,
                                                  logic [LANES-1:0] strb);
    logic [BUS_W-1:0] r;
    for (int unsigned l = 0; l < LANES; l++)
      r[l*8 +: 8] = strb[l] ? new_v[l*8 +: 8] : old_v[l*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/crc_lane_align.sv
module crc_lane_align
  import crc_pkg::*;
(
  input  logic [BUS_W-1:0] wdata,
  input  logic [LANES-1:0] wstrb,
  input  irev_e            irev,
  output logic             go,
  output logic [2:0]       nbytes,
  output logic [BUS_W-1:0] stream
);
  logic [1:0]       lo_lane;
  logic [BUS_W-1:0] raw, rev_b, rev_h, rev_w, picked;

  // strobe pattern -> access width and lowest lane
  always_comb begin
    go      = 1'b1;
    nbytes  = 3'd1;
    lo_lane = 2'd0;
    case (wstrb)
      4'b0001: lo_lane = 2'd0;
      4'b0010: lo_lane = 2'd1;
      4'b0100: lo_lane = 2'd2;
      4'b1000: lo_lane = 2'd3;
      4'b0011: nbytes  = 3'd2;
      4'b1100: begin nbytes = 3'd2; lo_lane = 2'd2; end
      4'b1111: nbytes  = 3'd4;
      default: begin go = 1'b0; nbytes = 3'd0; end
    endcase
  end

  // right-align the written bytes
  always_comb begin
    raw = wdata >> {lo_lane, 3'b000};
    case (nbytes)
      3'd1:    raw = raw & 32'h0000_00FF;
      3'd2:    raw = raw & 32'h0000_FFFF;
      3'd4:    raw = raw;
      default: raw = '0;
    endcase
  end

  assign rev_b = rev_units(raw, 8);
  assign rev_h = rev_units(raw, 16);
  assign rev_w = rev_units(raw, 32);

  // mirroring span is capped by the access width
  always_comb begin
    case (irev)
      IREV_NONE: picked = raw;
      IREV_BYTE: picked = rev_b;
      IREV_HALF: picked = (nbytes == 3'd1) ? rev_b : rev_h;
      default:   picked = (nbytes == 3'd1) ? rev_b :
                          (nbytes == 3'd2) ? rev_h : rev_w;
    endcase
  end

  // left-align so the first bit to fold sits at the MSB
  assign stream = picked << (6'd32 - {nbytes, 3'b000});
endmodule

// File: rtl/crc_fold_engine.sv
module crc_fold_engine
  import crc_pkg::*;
(
  input  logic [BUS_W-1:0] crc_in,
  input  logic [BUS_W-1:0] poly,
  input  psize_e           psize,
  input  logic [BUS_W-1:0] stream,
  input  logic [2:0]       nbytes,
  output logic [BUS_W-1:0] crc_out
);
  logic [BUS_W-1:0] mask, pm;
  logic [4:0]       tidx;
  logic [5:0]       nbits;
  logic [BUS_W-1:0] st [BUS_W+1];

  assign mask  = width_mask(psize);
  assign pm    = poly & mask;
  assign tidx  = top_index(psize);
  assign nbits = {nbytes, 3'b000};
  assign st[0] = crc_in & mask;

  for (genvar k = 0; k < BUS_W; k++) begin : g_bit
    localparam logic [5:0] KPOS = 6'(k);
    logic active, fb;
    assign active  = KPOS < nbits;
    assign fb      = st[k][tidx] ^ stream[BUS_W-1-k];
    assign st[k+1] = active ? (((st[k] << 1) ^ (fb ? pm : '0)) & mask) : st[k];
  end

  assign crc_out = st[BUS_W];
endmodule

// File: rtl/crc_out_shape.sv
module crc_out_shape
  import crc_pkg::*;
(
  input  logic [BUS_W-1:0] crc,
  input  psize_e           psize,
  input  logic             orev,
  output logic [BUS_W-1:0] result
);
  logic [BUS_W-1:0] masked, mirrored;

  assign masked   = crc & width_mask(psize);
  assign mirrored = rev_units(masked, BUS_W) >> refl_shift(psize);
  assign result   = orev ? mirrored : masked;
endmodule

// File: rtl/crc_periph.sv
module crc_periph
  import crc_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 5,
  parameter logic [BUS_W-1:0] INIT_RST = 32'hFFFF_FFFF,
  parameter logic [BUS_W-1:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [LANES-1:0]  wstrb,
  output logic [BUS_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'('h14);

  logic [BUS_W-1:0] crc_q, init_q, poly_q;
  psize_e           psize_q;
  irev_e            irev_q;
  logic             orev_q, rld_q;

  logic             go;
  logic [2:0]       nbytes;
  logic [BUS_W-1:0] stream, folded, shaped;
  logic [7:0]       ctrl_cur, ctrl_nx;
  logic             ctrl_unused;

  crc_lane_align u_align (
    .wdata (wdata), .wstrb (wstrb), .irev (irev_q),
    .go (go), .nbytes (nbytes), .stream (stream)
  );

  crc_fold_engine u_fold (
    .crc_in (crc_q), .poly (poly_q), .psize (psize_q),
    .stream (stream), .nbytes (nbytes), .crc_out (folded)
  );

  crc_out_shape u_shape (
    .crc (crc_q), .psize (psize_q), .orev (orev_q), .result (shaped)
  );

  assign ctrl_cur    = {orev_q, irev_q, psize_q, 3'b000};
  assign ctrl_nx     = wstrb[0] ? wdata[7:0] : ctrl_cur;
  assign ctrl_unused = ^ctrl_nx[2:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q   <= INIT_RST;
      init_q  <= INIT_RST;
      poly_q  <= POLY_RST;
      psize_q <= PSZ_32;
      irev_q  <= IREV_NONE;
      orev_q  <= 1'b0;
      rld_q   <= 1'b0;
    end else begin
      rld_q <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_DATA: if (go) crc_q <= folded;
          A_CTRL: begin
            psize_q <= psize_e'(ctrl_nx[4:3]);
            irev_q  <= irev_e'(ctrl_nx[6:5]);
            orev_q  <= ctrl_nx[7];
            if (ctrl_nx[0]) begin
              crc_q <= init_q & width_mask(psize_e'(ctrl_nx[4:3]));
              rld_q <= 1'b1;
            end
          end
          A_INIT: init_q <= byte_merge(init_q, wdata, wstrb);
          A_POLY: poly_q <= byte_merge(poly_q, wdata, wstrb);
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rdata = shaped;
      A_CTRL:  rdata = {24'b0, orev_q, irev_q, psize_q, 2'b00, rld_q};
      A_INIT:  rdata = init_q;
      A_POLY:  rdata = poly_q;
      default: rdata = '0;
    endcase
  end

  // reload takes the masked start value on the edge of the control write
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL && wstrb[0] && wdata[0])
    |=> crc_q == ($past(init_q) & width_mask(psize_e'($past(wdata[4:3])))));

  p_flag_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rld_q && !(wr_en && addr == A_CTRL && wstrb[0] && wdata[0])) |=> !rld_q);

  p_bad_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_DATA &&
     !(wstrb inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111}))
    |=> $stable(crc_q));

  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr == A_DATA || addr == A_CTRL)) |=> $stable(crc_q));

  p_rd_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (addr == A_DATA) |-> (rdata & ~width_mask(psize_q)) == '0);
endmodule

// File: tb/crc_periph_tb_top.sv
module crc_periph_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  crc_periph dut_i (
    .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr),
    .wdata (wdata), .wstrb (wstrb), .rdata (rdata)
  );

  typedef struct packed {
    logic [15:0] req;
    logic        chk;
    logic [4:0]  a;
    logic [3:0]  s;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 61;
  localparam vec_t VECS [NV] = '{
    // R2 default CRC-32 byte by byte, first four also place bytes in each lane (R3)
    '{"R2", 1'b0, 5'h04, 4'h1, 32'h0000_0001, 32'h0},
    '{"R2", 1'b0, 5'h00, 4'h1, 32'h0000_0031, 32'h0},
    '{"R2", 1'b0, 5'h00, 4'h2, 32'h0000_3200, 32'h0},
    '{"R2", 1'b0, 5'h00, 4'h4, 32'h0033_0000, 32'h0},
    '{"R2", 1'b0, 5'h00, 4'h8, 32'h3400_0000, 32'h0},
    '{"R2", 1'b0, 5'h00, 4'h1, 32'h0000_0035, 32'h0},
    '{"R2", 1'b0, 5'h00, 4'h1, 32'h0000_0036, 32'h0},
    '{"R2", 1'b0, 5'h00, 4'h1, 32'h0000_0037, 32'h0},
    '{"R2", 1'b0, 5'h00, 4'h1, 32'h0000_0038, 32'h0},
    '{"R2", 1'b1, 5'h00, 4'h1, 32'h0000_0039, 32'h0376_E6E7},
    // R3 word writes
    '{"R3", 1'b0, 5'h04, 4'h1, 32'h0000_0001, 32'h0},
    '{"R3", 1'b0, 5'h00, 4'hF, 32'h3132_3334, 32'h0},
    '{"R3", 1'b0, 5'h00, 4'hF, 32'h3536_3738, 32'h0},
    '{"R3", 1'b1, 5'h00, 4'h8, 32'h3900_0000, 32'h0376_E6E7},
    // R3 halfword writes in both halves
    '{"R3", 1'b0, 5'h04, 4'h1, 32'h0000_0001, 32'h0},
    '{"R3", 1'b0, 5'h00, 4'h3, 32'h0000_3132, 32'h0},
    '{"R3", 1'b0, 5'h00, 4'hC, 32'h3334_0000, 32'h0},
    '{"R3", 1'b0, 5'h00, 4'h3, 32'h0000_3536, 32'h0},
    '{"R3", 1'b0, 5'h00, 4'hC, 32'h3738_0000, 32'h0},
    '{"R3", 1'b1, 5'h00, 4'h1, 32'h0000_0039, 32'h0376_E6E7},
    // R10 zip-style: per-byte input mirror + output mirror
    '{"R10", 1'b0, 5'h04, 4'h1, 32'h0000_00A1, 32'h0},
    '{"R10", 1'b0, 5'h00, 4'h1, 32'h0000_0031, 32'h0},
    '{"R10", 1'b0, 5'h00, 4'h1, 32'h0000_0032, 32'h0},
    '{"R10", 1'b0, 5'h00, 4'h1, 32'h0000_0033, 32'h0},
    '{"R10", 1'b0, 5'h00, 4'h1, 32'h0000_0034, 32'h0},
    '{"R10", 1'b0, 5'h00, 4'h1, 32'h0000_0035, 32'h0},
    '{"R10", 1'b0, 5'h00, 4'h1, 32'h0000_0036, 32'h0},
    '{"R10", 1'b0, 5'h00, 4'h1, 32'h0000_0037, 32'h0},
    '{"R10", 1'b0, 5'h00, 4'h1, 32'h0000_0038, 32'h0},
    '{"R10", 1'b1, 5'h00, 4'h1, 32'h0000_0039, 32'h340B_C6D9},
    // R6 whole-word mirror with little-endian word writes
    '{"R6", 1'b0, 5'h04, 4'h1, 32'h0000_00E1, 32'h0},
    '{"R6", 1'b0, 5'h00, 4'hF, 32'h3433_3231, 32'h0},
    '{"R6", 1'b0, 5'h00, 4'hF, 32'h3837_3635, 32'h0},
    '{"R6", 1'b1, 5'h00, 4'h1, 32'h0000_0039, 32'h340B_C6D9},
    // R6 halfword mirror
    '{"R6", 1'b0, 5'h04, 4'h1, 32'h0000_00C1, 32'h0},
    '{"R6", 1'b0, 5'h00, 4'h3, 32'h0000_3231, 32'h0},
    '{"R6", 1'b0, 5'h00, 4'hC, 32'h3433_0000, 32'h0},
    '{"R6", 1'b0, 5'h00, 4'h3, 32'h0000_3635, 32'h0},
    '{"R6", 1'b0, 5'h00, 4'h3, 32'h0000_3837, 32'h0},
    '{"R6", 1'b1, 5'h00, 4'h1, 32'h0000_0039, 32'h340B_C6D9},
    // R6 per-byte mirror applied to word writes
    '{"R6", 1'b0, 5'h04, 4'h1, 32'h0000_00A1, 32'h0},
    '{"R6", 1'b0, 5'h00, 4'hF, 32'h3132_3334, 32'h0},
    '{"R6", 1'b0, 5'h00, 4'hF, 32'h3536_3738, 32'h0},
    '{"R6", 1'b1, 5'h00, 4'h1, 32'h0000_0039, 32'h340B_C6D9},
    // R8 16-bit
    '{"R8", 1'b0, 5'h14, 4'hF, 32'h0000_1021, 32'h0},
    '{"R8", 1'b0, 5'h10, 4'hF, 32'h0000_FFFF, 32'h0},
    '{"R8", 1'b0, 5'h04, 4'h1, 32'h0000_0009, 32'h0},
    '{"R8", 1'b0, 5'h00, 4'hF, 32'h3132_3334, 32'h0},
    '{"R8", 1'b0, 5'h00, 4'hF, 32'h3536_3738, 32'h0},
    '{"R8", 1'b1, 5'h00, 4'h1, 32'h0000_0039, 32'h0000_29B1},
    // R8 8-bit
    '{"R8", 1'b0, 5'h14, 4'hF, 32'h0000_0007, 32'h0},
    '{"R8", 1'b0, 5'h10, 4'hF, 32'h0000_0000, 32'h0},
    '{"R8", 1'b0, 5'h04, 4'h1, 32'h0000_0011, 32'h0},
    '{"R8", 1'b0, 5'h00, 4'hF, 32'h3132_3334, 32'h0},
    '{"R8", 1'b0, 5'h00, 4'hF, 32'h3536_3738, 32'h0},
    '{"R8", 1'b1, 5'h00, 4'h1, 32'h0000_0039, 32'h0000_00F4},
    // R8 7-bit
    '{"R8", 1'b0, 5'h14, 4'hF, 32'h0000_0009, 32'h0},
    '{"R8", 1'b0, 5'h04, 4'h1, 32'h0000_0019, 32'h0},
    '{"R8", 1'b0, 5'h00, 4'hF, 32'h3132_3334, 32'h0},
    '{"R8", 1'b0, 5'h00, 4'hF, 32'h3536_3738, 32'h0},
    '{"R8", 1'b1, 5'h00, 4'h1, 32'h0000_0039, 32'h0000_0075}
  };

  function automatic logic [31:0] ref_byte(logic [31:0] c, logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[31] ^ b[i];
      c  = c << 1;
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

  function automatic logic [31:0] mirror32(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    addr = a; wstrb = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v0, e_wide, e_byte;
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0; wstrb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    read_reg(5'h00, v); check("R1 data", v, 32'hFFFF_FFFF);
    read_reg(5'h04, v); check("R1 ctrl", v, 32'h0);
    read_reg(5'h10, v); check("R1 init", v, 32'hFFFF_FFFF);
    read_reg(5'h14, v); check("R1 poly", v, 32'h04C1_1DB7);
    read_reg(5'h08, v); check("R9 unmapped", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i].a, VECS[i].s, VECS[i].d);
      if (VECS[i].chk) begin
        read_reg(5'h00, v);
        check($sformatf("%s vec %0d", VECS[i].req, i), v, VECS[i].e);
      end
    end

    do_reset();

    // R3 full-width write folds four bytes
    e_wide = ref_byte(ref_byte(ref_byte(ref_byte(32'hFFFF_FFFF, 8'h00), 8'h00), 8'h00), 8'h31);
    bus_write(5'h00, 4'hF, 32'h0000_0031);
    read_reg(5'h00, v); check("R3 word write", v, e_wide);
    e_byte = ref_byte(32'hFFFF_FFFF, 8'h31);
    bus_write(5'h04, 4'h1, 32'h1);
    bus_write(5'h00, 4'h1, 32'h0000_0031);
    read_reg(5'h00, v); check("R3 byte write", v, e_byte);
    check("R3 widths differ", {31'b0, e_wide != e_byte}, 32'h1);

    // R4 malformed strobes leave CRC alone
    read_reg(5'h00, v0);
    bus_write(5'h00, 4'b0101, 32'h1234_5678);
    read_reg(5'h00, v); check("R4 strobe 0101", v, v0);
    bus_write(5'h00, 4'b0000, 32'h1234_5678);
    read_reg(5'h00, v); check("R4 strobe 0000", v, v0);
    bus_write(5'h00, 4'b0110, 32'h1234_5678);
    read_reg(5'h00, v); check("R4 strobe 0110", v, v0);

    // R7 output mirror, 32-bit
    bus_write(5'h04, 4'h1, 32'h0000_0081);
    bus_write(5'h00, 4'h1, 32'h0000_0031);
    read_reg(5'h00, v); check("R7 mirror out", v, mirror32(e_byte));

    // R9 byte-strobed register writes
    bus_write(5'h10, 4'b0101, 32'hAABB_CCDD);
    read_reg(5'h10, v); check("R9 init strobes", v, 32'hFFBB_FFDD);
    bus_write(5'h14, 4'b1000, 32'h1200_0000);
    read_reg(5'h14, v); check("R9 poly strobes", v, 32'h12C1_1DB7);
    bus_write(5'h14, 4'hF, 32'h04C1_1DB7);

    // R5 reload and one-cycle flag
    bus_write(5'h04, 4'h1, 32'h0000_0001);
    read_reg(5'h04, v); check("R5 flag set", v, 32'h0000_0001);
    read_reg(5'h00, v); check("R5 reload", v, 32'hFFBB_FFDD);
    @(negedge clk);
    read_reg(5'h04, v); check("R5 flag clear", v, 32'h0);

    // R9 control keeps only bits 7:3
    bus_write(5'h04, 4'hF, 32'hFFFF_FF7E);
    read_reg(5'h04, v); check("R9 ctrl reserved", v, 32'h0000_0078);

    // R8 narrow width masks read-back
    bus_write(5'h04, 4'h1, 32'h0000_0011);
    read_reg(5'h00, v); check("R8 width mask", v, 32'h0000_00DD);

    finish_run();
  end
endmodule